// File: doc/BRIEF.md
# Up-Counting Timer Channel with Dual Compare Output

This block is one channel of a general-purpose timer. A counter runs from zero up to a programmable terminal value and then wraps. Two compare registers make a single output pin toggle twice per period. The output returns to a programmable starting level whenever the counter restarts. Software programs the channel through a simple write port that has a strobe, a 3-bit register address and a data word. Software can also force the counter to zero, or load an arbitrary value into it.

The counter can be restarted by a synchronisation event. Three sources can raise that event: selected edges of an external sync pin, a bit in a software sync mask shared by all channels, or the sync event of the neighbouring channel. The channel keeps four sticky status flags: wrap, capture, compare 0 and compare 1. An interrupt line is raised by any flag whose enable bit is set. A single-cycle DMA request pulse follows one selected event.

Every stored count is the wanted count minus one. A terminal value R gives a period of R+1 clocks. A compare value C matches while the counter holds C.

Top module: `tmr_chan`

Register addresses: 0 control, 1 terminal value, 2 compare 0, 3 compare 1, 4 load value, 5 interrupt enable, 6 status clear.

Control word bits:

| Bit | Meaning |
|-----|---------|
| 0 | run |
| 1 | counter hold-at-zero |
| 2 | output enable |
| 3 | starting level |
| 4 | sync on falling edge |
| 5 | sync on rising edge |
| 6 | follow neighbour |
| 7 | software sync enable |
| 8 | DMA enable |
| 10:9 | DMA source |
| 11 | load strobe (not stored) |

## Requirements
- R1: After synchronous reset, the counter, the status flags, `irq`, `dma_req`, `sync_out` and `cmp_out` are all zero.
- R2: While run (control bit 0) is set, the counter steps up by one each clock. When it equals the terminal value (address 1) it returns to zero. That wrap sets status bit 0 and restores the starting level on the output.
- R3: While run is clear, the counter holds its value.
- R4: While control bit 1 is set, the counter is held at zero and the output is held at the starting level (control bit 3).
- R5: Writing the control word with bit 11 set loads the load value (address 4) into the counter on that clock edge. This load has priority over sync and counting.
- R6: While counting, the output toggles on the clock where the counter equals compare 0 (address 2), and again where it equals compare 1 (address 3). These matches set status bits 2 and 3. `cmp_out` is driven low while output enable (bit 2) is clear.
- R7: A rising edge of `sync_in` causes a sync event when bit 5 is set. A falling edge causes one when bit 4 is set. A sync event zeroes the counter and restores the starting level. An edge whose enable bit is clear has no effect.
- R8: A sync event also arises when bit 7 is set and bit `CH_IDX` of `sw_sync_mask` is high, or when bit 6 is set and `prev_sync` is high. Mask bits of other channels are ignored. `sync_out` pulses high one clock after each sync event of this channel.
- R9: Status flags are sticky. Writing ones to address 6 clears the matching flags. A flag set in the same clock wins over the clear. A high `cap_evt` sets status bit 1.
- R10: `irq` is high exactly while some status flag and its enable bit (address 5, same bit layout) are both set.
- R11: `dma_req` pulses for one clock when DMA enable (bit 8) is set and the source picked by bits 10:9 fires. The source codes are 0 compare 0, 1 compare 1, 2 `in_toggle`, 3 wrap. The pulse appears together with the status flag of that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| sw_sync_mask | input | NCH | Software sync mask, one bit per channel |
| sync_in | input | 1 | External sync pin |
| prev_sync | input | 1 | Sync event from the neighbouring channel |
| cap_evt | input | 1 | Capture event from the capture path |
| in_toggle | input | 1 | Input toggle event for DMA |
| cnt_val | output | W | Counter value |
| status | output | 4 | Status flags: wrap, capture, cmp0, cmp1 |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request pulse |
| sync_out | output | 1 | Registered sync event for the next channel |

## Verification
The main counting function is exercised with:
- a short period whose compares fall inside the period, which distinguishes the two toggle points from the wrap restore;
- a run/stop sequence, which separates freezing from clearing;
- a hold-at-zero and a load strobe, which check the priority between load, hold and count.

Sync is tried with:
- an enabled rising edge followed by a disabled falling edge;
- a software mask bit belonging to another channel, then this channel's own bit;
- a pulse from the neighbouring channel.

This sequence shows that only the selected sources restart the counter. A cycle-accurate reference model runs beside the design, so status, interrupt and DMA outputs are compared on every clock, and not only at the directed checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W  = 3;
  localparam int NCMP    = 2;
  localparam int NFLAG   = 4;
  localparam int UPD_BIT = 11;
  localparam int FL_WRAP = 0;
  localparam int FL_CAP  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_CMP0   = 3'd2,
    A_CMP1   = 3'd3,
    A_LOADV  = 3'd4,
    A_IRQEN  = 3'd5,
    A_STCLR  = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    DMA_CMP0   = 2'd0,
    DMA_CMP1   = 2'd1,
    DMA_TOGGLE = 2'd2,
    DMA_WRAP   = 2'd3
  } dma_sel_e;

  typedef struct packed {
    dma_sel_e dma_sel;
    logic     dma_en;
    logic     sw_en;
    logic     follow;
    logic     rise_en;
    logic     fall_en;
    logic     init_pol;
    logic     out_en;
    logic     cnt_rst;
    logic     run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [W-1:0]             wr_data,
  output ctrl_t                    ctrl,
  output logic [W-1:0]             rld,
  output logic [NCMP-1:0][W-1:0]   cmp,
  output logic [W-1:0]             loadv,
  output logic [NFLAG-1:0]         irqen,
  output logic                     upd,
  output logic [NFLAG-1:0]         clr
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr);

  assign upd = wr_en && (addr == A_CTRL) && wr_data[UPD_BIT];
  assign clr = (wr_en && (addr == A_STCLR)) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      rld   <= '0;
      loadv <= '0;
      irqen <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:   ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_RELOAD: rld   <= wr_data;
        A_LOADV:  loadv <= wr_data;
        A_IRQEN:  irqen <= wr_data[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) cmp[gi] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(A_CMP0) + ADDR_W'(gi))) cmp[gi] <= wr_data;
    end
  end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync import tmr_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  sync_in,
  input  logic  sw_hit,
  input  logic  prev_sync,
  output logic  sync_evt,
  output logic  sync_out
);
  logic pin_q;
  logic rise, fall;

  assign rise     = sync_in & ~pin_q;
  assign fall     = ~sync_in & pin_q;
  assign sync_evt = (ctrl.rise_en & rise) | (ctrl.fall_en & fall) |
                    (ctrl.sw_en & sw_hit) | (ctrl.follow & prev_sync);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      pin_q    <= sync_in;
      sync_out <= sync_evt;
    end
  end

  assert_sync_out_R8: assert property (@(posedge clk) disable iff (rst)
    sync_evt |=> sync_out);
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrl_t                  ctrl,
  input  logic                   upd,
  input  logic [W-1:0]           loadv,
  input  logic [W-1:0]           rld,
  input  logic [NCMP-1:0][W-1:0] cmp,
  input  logic                   sync_evt,
  output logic [W-1:0]           cnt_q,
  output logic                   out_q,
  output logic [NCMP-1:0]        match,
  output logic                   wrap
);
  localparam logic [W-1:0] ONE = W'(1);
  logic step;

  assign step = ctrl.run & ~ctrl.cnt_rst & ~upd & ~sync_evt;
  assign wrap = step & (cnt_q == rld);

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_match
    assign match[gi] = step & (cnt_q == cmp[gi]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (ctrl.cnt_rst) begin
      cnt_q <= '0;
      out_q <= ctrl.init_pol;
    end else if (upd) begin
      cnt_q <= loadv;
    end else if (sync_evt) begin
      cnt_q <= '0;
      out_q <= ctrl.init_pol;
    end else if (wrap) begin
      cnt_q <= '0;
      out_q <= ctrl.init_pol;
    end else if (step) begin
      cnt_q <= cnt_q + ONE;
      out_q <= out_q ^ (^match);
    end
  end

  assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !ctrl.cnt_rst && !upd && !sync_evt) |=> $stable(cnt_q));
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && !ctrl.cnt_rst) |=> (cnt_q == $past(loadv)));
  assert_sync_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (sync_evt && !ctrl.cnt_rst && !upd) |=> (cnt_q == '0));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0 && out_q == $past(ctrl.init_pol)));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags import tmr_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [NCMP-1:0]   match,
  input  logic              wrap,
  input  logic              cap_evt,
  input  logic              in_toggle,
  input  logic [NFLAG-1:0]  clr,
  input  logic [NFLAG-1:0]  irqen,
  output logic [NFLAG-1:0]  status_q,
  output logic              irq,
  output logic              dma_req
);
  logic [NFLAG-1:0] set_v;
  logic             pick;

  assign set_v = {match, cap_evt, wrap};
  assign irq   = |(status_q & irqen);

  always_comb begin
    case (ctrl.dma_sel)
      DMA_CMP0:   pick = match[0];
      DMA_CMP1:   pick = match[1];
      DMA_TOGGLE: pick = in_toggle;
      default:    pick = wrap;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      dma_req  <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | set_v;
      dma_req  <= ctrl.dma_en & pick;
    end
  end

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (status_q[gi] && !clr[gi]) |=> status_q[gi]);
  end

  assert_dma_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrl.dma_en |=> !dma_req);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int W      = 16,
  parameter int NCH    = 4,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [NCH-1:0]    sw_sync_mask,
  input  logic              sync_in,
  input  logic              prev_sync,
  input  logic              cap_evt,
  input  logic              in_toggle,
  output logic [W-1:0]      cnt_val,
  output logic [NFLAG-1:0]  status,
  output logic              cmp_out,
  output logic              irq,
  output logic              dma_req,
  output logic              sync_out
);
  ctrl_t                  ctrl;
  logic [W-1:0]           rld, loadv;
  logic [NCMP-1:0][W-1:0] cmp;
  logic [NFLAG-1:0]       irqen, clr;
  logic                   upd, sync_evt, out_q, wrap;
  logic [NCMP-1:0]        match;
  logic                   unused_mask;

  assign unused_mask = ^sw_sync_mask;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .rld(rld), .cmp(cmp), .loadv(loadv), .irqen(irqen),
    .upd(upd), .clr(clr)
  );

  tmr_sync u_sync (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sync_in(sync_in),
    .sw_hit(sw_sync_mask[CH_IDX]), .prev_sync(prev_sync),
    .sync_evt(sync_evt), .sync_out(sync_out)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl), .upd(upd), .loadv(loadv), .rld(rld),
    .cmp(cmp), .sync_evt(sync_evt), .cnt_q(cnt_val), .out_q(out_q),
    .match(match), .wrap(wrap)
  );

  tmr_flags u_flags (
    .clk(clk), .rst(rst), .ctrl(ctrl), .match(match), .wrap(wrap),
    .cap_evt(cap_evt), .in_toggle(in_toggle), .clr(clr), .irqen(irqen),
    .status_q(status), .irq(irq), .dma_req(dma_req)
  );

  assign cmp_out = ctrl.out_en & out_q;

  assert_out_en_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl.out_en |-> !cmp_out);
endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  localparam int CLK_P = 10;
  localparam int W = 16;
  localparam int CTRL = 0, RLD = 1, CMP0 = 2, CMP1 = 3, LDV = 4, IEN = 5, SCLR = 6;
  localparam int B_RUN = 1, B_HOLD = 2, B_OE = 4, B_INIT = 8, B_FALL = 16, B_RISE = 32,
                 B_FOL = 64, B_SW = 128, B_DMA = 256, B_UPD = 2048;

  logic clk = 0, rst = 1, wr_en = 0, sync_in = 0, prev_sync = 0, cap_evt = 0, in_toggle = 0;
  logic [2:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [3:0] sw_sync_mask = 0;
  logic [W-1:0] cnt_val;
  logic [3:0] status;
  logic cmp_out, irq, dma_req, sync_out;
  int checks = 0, errors = 0;
  bit chk_on = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_chan #(.W(W), .NCH(4), .CH_IDX(1)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_sync_mask(sw_sync_mask), .sync_in(sync_in), .prev_sync(prev_sync),
    .cap_evt(cap_evt), .in_toggle(in_toggle), .cnt_val(cnt_val), .status(status),
    .cmp_out(cmp_out), .irq(irq), .dma_req(dma_req), .sync_out(sync_out)
  );

  // reference model state
  int m_cnt, m_out, m_st, m_dma, m_so, m_sq;
  int m_run, m_hold, m_oe, m_init, m_fall, m_rise, m_fol, m_sw, m_den, m_sel;
  int m_rld, m_c0, m_c1, m_ldv, m_ie;

  always @(posedge clk) begin
    int sev, upd, step, h0, h1, hw, clr, pick;
    if (rst) begin
      m_cnt = 0; m_out = 0; m_st = 0; m_dma = 0; m_so = 0; m_sq = 0;
      m_run = 0; m_hold = 0; m_oe = 0; m_init = 0; m_fall = 0; m_rise = 0;
      m_fol = 0; m_sw = 0; m_den = 0; m_sel = 0;
      m_rld = 0; m_c0 = 0; m_c1 = 0; m_ldv = 0; m_ie = 0;
    end else begin
      sev = ((m_rise != 0) && sync_in && (m_sq == 0)) || ((m_fall != 0) && !sync_in && (m_sq != 0)) ||
            ((m_sw != 0) && sw_sync_mask[1]) || ((m_fol != 0) && prev_sync);
      upd = wr_en && (wr_addr == 0) && wr_data[11];
      step = (m_run != 0) && (m_hold == 0) && !upd && !sev;
      h0 = step && (m_cnt == m_c0);
      h1 = step && (m_cnt == m_c1);
      hw = step && (m_cnt == m_rld);
      if (m_hold != 0) begin m_cnt = 0; m_out = m_init; end
      else if (upd) m_cnt = m_ldv;
      else if (sev) begin m_cnt = 0; m_out = m_init; end
      else if (hw) begin m_cnt = 0; m_out = m_init; end
      else if (step) begin
        m_cnt = (m_cnt + 1) % 65536;
        if (h0) m_out = 1 - m_out;
        if (h1) m_out = 1 - m_out;
      end
      clr = (wr_en && wr_addr == 6) ? int'(wr_data[3:0]) : 0;
      m_st = ((m_st & ~clr) | (h1 << 3) | (h0 << 2) | (int'(cap_evt) << 1) | hw) & 15;
      case (m_sel)
        0: pick = h0;
        1: pick = h1;
        2: pick = int'(in_toggle);
        default: pick = hw;
      endcase
      m_dma = ((m_den != 0) && (pick != 0)) ? 1 : 0;
      m_so = sev;
      m_sq = int'(sync_in);
      if (wr_en) begin
        case (wr_addr)
          0: begin
            m_run = wr_data[0]; m_hold = wr_data[1]; m_oe = wr_data[2]; m_init = wr_data[3];
            m_fall = wr_data[4]; m_rise = wr_data[5]; m_fol = wr_data[6]; m_sw = wr_data[7];
            m_den = wr_data[8]; m_sel = int'(wr_data[10:9]);
          end
          1: m_rld = wr_data;
          2: m_c0 = wr_data;
          3: m_c1 = wr_data;
          4: m_ldv = wr_data;
          5: m_ie = wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 counter lockstep", cnt_val, m_cnt);
      chk("R6 cmp_out lockstep", cmp_out, (m_oe != 0) ? m_out : 0);
      chk("R9 status lockstep", status, m_st);
      chk("R10 irq lockstep", irq, ((m_st & m_ie) != 0) ? 1 : 0);
      chk("R11 dma_req lockstep", dma_req, m_dma);
      chk("R8 sync_out lockstep", sync_out, m_so);
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[W-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk_on = 1;
    chk("R1 reset counter", cnt_val, 0);
    chk("R1 reset status", status, 0);
    chk("R1 reset outputs", {irq, dma_req, sync_out, cmp_out}, 0);
    rst = 0;
    @(negedge clk);

    wr(RLD, 4); wr(CMP0, 1); wr(CMP1, 3); wr(IEN, 15);
    wr(CTRL, B_RUN | B_OE | B_DMA | (3 << 9));
    repeat (12) @(negedge clk);
    while (cnt_val != 4) @(negedge clk);
    @(negedge clk);
    chk("R2 wrap to zero", cnt_val, 0);

    wr(CTRL, B_OE);
    v = cnt_val;
    repeat (3) @(negedge clk);
    chk("R3 frozen while stopped", cnt_val, v);

    wr(LDV, 2);
    wr(CTRL, B_OE | B_UPD);
    chk("R5 load value", cnt_val, 2);

    wr(CTRL, B_RUN | B_OE | B_HOLD | B_INIT);
    @(negedge clk);
    chk("R4 hold zero", cnt_val, 0);
    chk("R4 starting level", cmp_out, 1);
    repeat (2) @(negedge clk);
    chk("R4 still zero", cnt_val, 0);

    wr(CTRL, B_RUN | B_OE | B_INIT);
    while (cnt_val != 2) @(negedge clk);
    chk("R6 toggled at cmp0", cmp_out, 0);
    while (cnt_val != 4) @(negedge clk);
    chk("R6 toggled at cmp1", cmp_out, 1);
    wr(CTRL, B_RUN | B_INIT);
    chk("R6 output disabled", cmp_out, 0);

    wr(CTRL, B_RUN | B_OE | B_RISE);
    while (cnt_val != 2) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    chk("R7 rising edge zeroes", cnt_val, 0);
    chk("R8 sync_out pulse", sync_out, 1);
    @(negedge clk);
    sync_in = 0;
    @(negedge clk);
    chk("R7 falling edge ignored", cnt_val, 2);

    wr(CTRL, B_RUN | B_OE | B_SW);
    v = cnt_val;
    sw_sync_mask = 4'b0001;
    @(negedge clk);
    sw_sync_mask = 0;
    chk("R8 other channel mask ignored", cnt_val, (v == 4) ? 0 : v + 1);
    while (cnt_val != 3) @(negedge clk);
    sw_sync_mask = 4'b0010;
    @(negedge clk);
    sw_sync_mask = 0;
    chk("R8 software sync", cnt_val, 0);

    wr(CTRL, B_RUN | B_OE | B_FOL);
    while (cnt_val != 3) @(negedge clk);
    prev_sync = 1;
    @(negedge clk);
    prev_sync = 0;
    chk("R8 follow neighbour", cnt_val, 0);

    wr(CTRL, B_OE);
    wr(SCLR, 15);
    chk("R9 cleared", status, 0);
    cap_evt = 1;
    @(negedge clk);
    cap_evt = 0;
    chk("R9 capture flag", status, 2);
    cap_evt = 1;
    wr(SCLR, 2);
    cap_evt = 0;
    chk("R9 set wins over clear", status, 2);

    wr(IEN, 2);
    chk("R10 irq enabled flag", irq, 1);
    wr(IEN, 1);
    chk("R10 irq masked", irq, 0);

    wr(CTRL, B_DMA | (2 << 9));
    in_toggle = 1;
    @(negedge clk);
    in_toggle = 0;
    chk("R11 dma on toggle", dma_req, 1);
    @(negedge clk);
    chk("R11 dma single pulse", dma_req, 0);
    wr(CTRL, (2 << 9));
    in_toggle = 1;
    @(negedge clk);
    in_toggle = 0;
    chk("R11 dma disabled", dma_req, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule